// File: doc/BRIEF.md
# Key-Value Query Dispatcher for a Rack Switch

This block sits in the switch pipeline after the header parser and the cache key lookup. It receives one parsed key-value query per cycle: opcode, sequence number, key, value, the two endpoint addresses, the transport destination port and a flag that says whether the packet came from a storage server. It also receives the lookup result for the key: a hit flag, the slot number and the value held in that slot. From these inputs it picks one action. The switch can answer the client directly from the cache, send the query on to storage, absorb a cache fill, or leave the packet to normal forwarding.

The block keeps one valid flag per cache slot. A write or delete that hits a slot clears the flag before the query is forwarded, so a later read cannot be served with old data. A cache-update operation fills the slot and sets the flag again. Reads also produce a statistics record. The record names the slot for cached keys and the key for uncached ones. All results come from registers and appear one cycle after the query is accepted.

Top module: `kvd_dispatch`

## Requirements
- R1: After reset no output strobe is active and every slot is invalid, so a read that hits any slot is handled as a miss.
- R2: A packet whose destination port differs from the reserved port `KV_PORT` leaves with action PASS (0). Its addresses, seq, key and value are unchanged. It produces no statistics, invalidate or store strobe, and it does not change any valid flag.
- R3: A read (op 0) that hits a valid slot leaves with action REPLY (1). The output carries the cached value and the swapped addresses (out_src = in_dst, out_dst = in_src), and the seq is unchanged. A statistics record is issued with stat_cached=1 and the hit slot.
- R4: A read that misses leaves with action FORWARD (2), with addresses and value unchanged. A statistics record is issued with stat_cached=0 and the query key.
- R5: A read that hits a slot whose valid flag is clear is handled exactly as a miss (R4).
- R6: A write (op 1) or delete (op 2) that hits a slot leaves with action FORWARD. It pulses inval_strobe with that slot and clears the slot's valid flag, so the next read to that slot is forwarded.
- R7: A write or delete that misses is forwarded. It produces no invalidate strobe and no statistics record.
- R8: A cache update (op 3) leaves with action CONSUME (3). It pulses store_we with the lookup slot and the packet value, and it sets the slot's valid flag. It produces no statistics record.
- R9: A packet on the reserved port that comes from a server and is not a cache update is forwarded unchanged. It produces no statistics record and leaves the valid flags alone.
- R10: Every result appears exactly one cycle after the input cycle with in_valid high. A cycle with in_valid low produces no output strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Query present this cycle |
| in_dport | input | PORT_W | Transport destination port |
| in_from_srv | input | 1 | Packet arrived from a storage server |
| in_op | input | 2 | Opcode: 0 read, 1 write, 2 delete, 3 cache update |
| in_seq | input | SEQ_W | Sequence number |
| in_key | input | KEY_W | Query key |
| in_value | input | VAL_W | Value carried by the packet |
| in_src | input | ADDR_W | Source address |
| in_dst | input | ADDR_W | Destination address |
| lk_hit | input | 1 | Key found in the cache lookup table |
| lk_slot | input | SLOT_W | Slot of the key (target slot for a cache update) |
| lk_value | input | VAL_W | Value held in that slot |
| out_valid | output | 1 | Result present |
| out_action | output | 2 | 0 pass, 1 reply, 2 forward, 3 consume |
| out_src | output | ADDR_W | Outgoing source address |
| out_dst | output | ADDR_W | Outgoing destination address |
| out_seq | output | SEQ_W | Outgoing sequence number |
| out_key | output | KEY_W | Outgoing key |
| out_value | output | VAL_W | Outgoing value |
| stat_valid | output | 1 | Statistics record present |
| stat_cached | output | 1 | Record is for a cached key (slot) rather than an uncached key |
| stat_slot | output | SLOT_W | Slot counted |
| stat_key | output | KEY_W | Key counted |
| inval_strobe | output | 1 | A slot was invalidated |
| inval_slot | output | SLOT_W | Slot invalidated |
| store_we | output | 1 | Write cache value store |
| store_slot | output | SLOT_W | Slot to write |
| store_data | output | VAL_W | Value to write |

## Verification
Every output is due on the clock edge that follows the input cycle. The bench drives inputs on the falling edge, waits one falling edge and reads the result, which lies between those two edges. A change to a valid flag takes effect on that same edge, so the bench watches it through the action of the next read to the slot, sent right after. The idle cycles after each query show that nothing appears without in_valid (R10).

// File: rtl/kvd_pkg.sv
package kvd_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_DELETE = 2'd2,
    OP_CUPD   = 2'd3
  } kv_op_e;

  typedef enum logic [1:0] {
    ACT_PASS    = 2'd0,
    ACT_REPLY   = 2'd1,
    ACT_FORWARD = 2'd2,
    ACT_CONSUME = 2'd3
  } kv_act_e;

  typedef struct packed {
    kv_act_e act;
    logic    swap;
    logic    use_cached;
    logic    stat;
    logic    stat_cached;
    logic    inval;
    logic    fill;
  } kv_dec_t;

  // Pure decision table: what to do with one query.
  function automatic kv_dec_t kv_decide(input logic on_port, input logic from_srv,
                                        input logic [1:0] op, input logic hit,
                                        input logic entry_ok);
    kv_dec_t d;
    d = '{act: ACT_PASS, swap: 1'b0, use_cached: 1'b0, stat: 1'b0,
          stat_cached: 1'b0, inval: 1'b0, fill: 1'b0};
    if (on_port) begin
      if (from_srv && kv_op_e'(op) != OP_CUPD) begin
        d.act = ACT_FORWARD;
      end else begin
        case (kv_op_e'(op))
          OP_READ: begin
            d.stat = 1'b1;
            if (hit && entry_ok) begin
              d.act         = ACT_REPLY;
              d.swap        = 1'b1;
              d.use_cached  = 1'b1;
              d.stat_cached = 1'b1;
            end else begin
              d.act = ACT_FORWARD;
            end
          end
          OP_WRITE, OP_DELETE: begin
            d.act   = ACT_FORWARD;
            d.inval = hit;
          end
          default: begin
            d.act  = ACT_CONSUME;
            d.fill = 1'b1;
          end
        endcase
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/kvd_valid_table.sv
module kvd_valid_table #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_ok,
  output logic [SLOTS-1:0]  valid_vec
);

  logic [SLOTS-1:0] valid_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
      end else if (set_en && set_slot == SLOT_W'(s)) begin
        valid_q[s] <= 1'b1;
      end else if (clr_en && clr_slot == SLOT_W'(s)) begin
        valid_q[s] <= 1'b0;
      end
    end
  end

  assign rd_ok     = valid_q[rd_slot];
  assign valid_vec = valid_q;

endmodule

// File: rtl/kvd_classify.sv
module kvd_classify #(
  parameter int          PORT_W  = 16,
  parameter logic [15:0] KV_PORT = 16'd8890
) (
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_dport,
  input  logic              in_from_srv,
  input  logic [1:0]        in_op,
  input  logic              lk_hit,
  input  logic              entry_ok,
  output kvd_pkg::kv_dec_t  dec,
  output logic              on_port
);
  import kvd_pkg::*;

  assign on_port = (in_dport == PORT_W'(KV_PORT));

  always_comb begin
    dec = kv_decide(on_port, in_from_srv, in_op, lk_hit, entry_ok);
    if (!in_valid) begin
      dec.stat  = 1'b0;
      dec.inval = 1'b0;
      dec.fill  = 1'b0;
    end
  end

endmodule

// File: rtl/kvd_dispatch.sv
module kvd_dispatch #(
  parameter int          SLOTS   = 16,
  parameter int          KEY_W   = 16,
  parameter int          VAL_W   = 32,
  parameter int          SEQ_W   = 16,
  parameter int          ADDR_W  = 32,
  parameter int          PORT_W  = 16,
  parameter logic [15:0] KV_PORT = 16'd8890,
  localparam int         SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_dport,
  input  logic              in_from_srv,
  input  logic [1:0]        in_op,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [VAL_W-1:0]  in_value,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic              lk_hit,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [VAL_W-1:0]  lk_value,
  output logic              out_valid,
  output logic [1:0]        out_action,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [KEY_W-1:0]  out_key,
  output logic [VAL_W-1:0]  out_value,
  output logic              stat_valid,
  output logic              stat_cached,
  output logic [SLOT_W-1:0] stat_slot,
  output logic [KEY_W-1:0]  stat_key,
  output logic              inval_strobe,
  output logic [SLOT_W-1:0] inval_slot,
  output logic              store_we,
  output logic [SLOT_W-1:0] store_slot,
  output logic [VAL_W-1:0]  store_data
);
  import kvd_pkg::*;

  // Named internal events (observed by the checker)
  kv_dec_t          dec;
  logic             on_port;
  logic             entry_ok;
  logic [SLOTS-1:0] valid_vec;
  logic             clr_ev;
  logic             set_ev;

  kvd_classify #(.PORT_W(PORT_W), .KV_PORT(KV_PORT)) u_cls (
    .in_valid    (in_valid),
    .in_dport    (in_dport),
    .in_from_srv (in_from_srv),
    .in_op       (in_op),
    .lk_hit      (lk_hit),
    .entry_ok    (entry_ok),
    .dec         (dec),
    .on_port     (on_port)
  );

  assign clr_ev = dec.inval;
  assign set_ev = dec.fill;

  kvd_valid_table #(.SLOTS(SLOTS)) u_vt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_en    (clr_ev),
    .clr_slot  (lk_slot),
    .set_en    (set_ev),
    .set_slot  (lk_slot),
    .rd_slot   (lk_slot),
    .rd_ok     (entry_ok),
    .valid_vec (valid_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_action   <= ACT_PASS;
      out_src      <= '0;
      out_dst      <= '0;
      out_seq      <= '0;
      out_key      <= '0;
      out_value    <= '0;
      stat_valid   <= 1'b0;
      stat_cached  <= 1'b0;
      stat_slot    <= '0;
      stat_key     <= '0;
      inval_strobe <= 1'b0;
      inval_slot   <= '0;
      store_we     <= 1'b0;
      store_slot   <= '0;
      store_data   <= '0;
    end else begin
      out_valid    <= in_valid && !(dec.act == ACT_CONSUME);
      out_action   <= dec.act;
      out_src      <= dec.swap ? in_dst : in_src;
      out_dst      <= dec.swap ? in_src : in_dst;
      out_seq      <= in_seq;
      out_key      <= in_key;
      out_value    <= dec.use_cached ? lk_value : in_value;
      stat_valid   <= dec.stat;
      stat_cached  <= dec.stat_cached;
      stat_slot    <= lk_slot;
      stat_key     <= in_key;
      inval_strobe <= clr_ev;
      inval_slot   <= lk_slot;
      store_we     <= set_ev;
      store_slot   <= lk_slot;
      store_data   <= in_value;
    end
  end

endmodule

// File: rtl/kvd_dispatch_chk.sv
module kvd_dispatch_chk #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int SEQ_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SEQ_W-1:0]  in_seq,
  input logic              out_valid,
  input logic [1:0]        out_action,
  input logic [SEQ_W-1:0]  out_seq,
  input logic              stat_valid,
  input logic              stat_cached,
  input logic              inval_strobe,
  input logic [SLOT_W-1:0] inval_slot,
  input logic              store_we,
  input logic [SLOT_W-1:0] store_slot,
  input logic [SLOTS-1:0]  valid_vec
);

  // R2: passed packets never count
  a_r2_pass_no_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_action == 2'd0) |-> !stat_valid && !inval_strobe);

  // R3: a reply is always counted as a cached hit and keeps the seq
  a_r3_reply_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_action == 2'd1) |-> (stat_valid && stat_cached));

  a_r3_seq_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid ##1 (out_valid && out_action == 2'd1)) |-> out_seq == $past(in_seq));

  // R6: invalidation goes with a forward and leaves the flag clear
  a_r6_inval_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    inval_strobe |-> (out_valid && out_action == 2'd2 && !valid_vec[inval_slot]));

  // R8: a fill is consumed and leaves the flag set
  a_r8_fill_set: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> (!out_valid && valid_vec[store_slot] && !stat_valid));

  // R10: nothing appears after an idle cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(out_valid || stat_valid || inval_strobe || store_we));

endmodule

bind kvd_dispatch kvd_dispatch_chk #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_seq       (in_seq),
  .out_valid    (out_valid),
  .out_action   (out_action),
  .out_seq      (out_seq),
  .stat_valid   (stat_valid),
  .stat_cached  (stat_cached),
  .inval_strobe (inval_strobe),
  .inval_slot   (inval_slot),
  .store_we     (store_we),
  .store_slot   (store_slot),
  .valid_vec    (valid_vec)
);

// File: tb/kvd_dispatch_tb.sv
module kvd_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KVP = 16'd8890;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_dport = '0;
  logic        in_from_srv = 1'b0;
  logic [1:0]  in_op = '0;
  logic [15:0] in_seq = '0;
  logic [15:0] in_key = '0;
  logic [31:0] in_value = '0;
  logic [31:0] in_src = '0;
  logic [31:0] in_dst = '0;
  logic        lk_hit = 1'b0;
  logic [3:0]  lk_slot = '0;
  logic [31:0] lk_value = '0;
  logic        out_valid;
  logic [1:0]  out_action;
  logic [31:0] out_src, out_dst, out_value;
  logic [15:0] out_seq, out_key, stat_key;
  logic        stat_valid, stat_cached, inval_strobe, store_we;
  logic [3:0]  stat_slot, inval_slot, store_slot;
  logic [31:0] store_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kvd_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dport(in_dport),
    .in_from_srv(in_from_srv), .in_op(in_op), .in_seq(in_seq), .in_key(in_key),
    .in_value(in_value), .in_src(in_src), .in_dst(in_dst), .lk_hit(lk_hit),
    .lk_slot(lk_slot), .lk_value(lk_value), .out_valid(out_valid),
    .out_action(out_action), .out_src(out_src), .out_dst(out_dst),
    .out_seq(out_seq), .out_key(out_key), .out_value(out_value),
    .stat_valid(stat_valid), .stat_cached(stat_cached), .stat_slot(stat_slot),
    .stat_key(stat_key), .inval_strobe(inval_strobe), .inval_slot(inval_slot),
    .store_we(store_we), .store_slot(store_slot), .store_data(store_data)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one query on a falling edge; return after the result edge.
  task automatic send(input logic [15:0] port, input logic srv, input logic [1:0] op,
                      input logic [15:0] seq, input logic [15:0] key,
                      input logic [31:0] val, input logic hit, input logic [3:0] slot,
                      input logic [31:0] cval);
    in_valid = 1'b1; in_dport = port; in_from_srv = srv; in_op = op;
    in_seq = seq; in_key = key; in_value = val; in_src = 32'hC11E_0001;
    in_dst = 32'h5E5E_0002; lk_hit = hit; lk_slot = slot; lk_value = cval;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Read to a slot, returns the action observed
  task automatic probe_read(input logic [3:0] slot, output logic [1:0] act);
    send(KVP, 1'b0, 2'd0, 16'h0, 16'h77, 32'h0, 1'b1, slot, 32'hAAAA);
    act = out_action;
  endtask

  task automatic t_reset;
    logic [1:0] a;
    check("R1", "out_valid", out_valid, 0);
    check("R1", "stat_valid", stat_valid, 0);
    check("R1", "store_we", store_we, 0);
    probe_read(4'd5, a);
    check("R1", "read hit after reset forwarded", a, 2);
  endtask

  task automatic t_fill(input logic [3:0] slot, input logic [31:0] v);
    send(KVP, 1'b1, 2'd3, 16'h10, 16'h20, v, 1'b0, slot, 32'h0);
    check("R8", "store_we", store_we, 1);
    check("R8", "store_slot", store_slot, slot);
    check("R8", "store_data", store_data, v);
    check("R8", "action consume", out_action, 3);
    check("R8", "no stat", stat_valid, 0);
  endtask

  task automatic t_read_hit;
    send(KVP, 1'b0, 2'd0, 16'hBEEF, 16'h42, 32'h1111, 1'b1, 4'd3, 32'hCAFE_F00D);
    check("R3", "out_valid", out_valid, 1);
    check("R3", "action reply", out_action, 1);
    check("R3", "value", out_value, 32'hCAFE_F00D);
    check("R3", "src swapped", out_src, 32'h5E5E_0002);
    check("R3", "dst swapped", out_dst, 32'hC11E_0001);
    check("R3", "seq", out_seq, 16'hBEEF);
    check("R3", "stat cached", {stat_valid, stat_cached, stat_slot}, {2'b11, 4'd3});
  endtask

  task automatic t_read_miss;
    send(KVP, 1'b0, 2'd0, 16'h5, 16'h99, 32'h2222, 1'b0, 4'd3, 32'hDEAD);
    check("R4", "action forward", out_action, 2);
    check("R4", "value kept", out_value, 32'h2222);
    check("R4", "src kept", out_src, 32'hC11E_0001);
    check("R4", "stat uncached", {stat_valid, stat_cached, stat_key}, {2'b10, 16'h99});
  endtask

  task automatic t_read_invalid;
    send(KVP, 1'b0, 2'd0, 16'h6, 16'h55, 32'h0, 1'b1, 4'd9, 32'hDEAD);
    check("R5", "invalid hit forwarded", out_action, 2);
    check("R5", "stat uncached", {stat_valid, stat_cached}, 2'b10);
  endtask

  task automatic t_write_hit(input logic [1:0] op, input logic [3:0] slot);
    logic [1:0] a;
    send(KVP, 1'b0, op, 16'h7, 16'h42, 32'h3333, 1'b1, slot, 32'h0);
    check("R6", "action forward", out_action, 2);
    check("R6", "inval strobe/slot", {inval_strobe, inval_slot}, {1'b1, slot});
    check("R6", "no stat", stat_valid, 0);
    probe_read(slot, a);
    check("R6", "read after invalidate forwarded", a, 2);
  endtask

  task automatic t_write_miss;
    send(KVP, 1'b0, 2'd2, 16'h8, 16'h43, 32'h4444, 1'b0, 4'd3, 32'h0);
    check("R7", "action forward", out_action, 2);
    check("R7", "no inval", inval_strobe, 0);
    check("R7", "no stat", stat_valid, 0);
  endtask

  task automatic t_passthru(input logic [3:0] slot);
    logic [1:0] a;
    send(16'd80, 1'b0, 2'd1, 16'h9, 16'h44, 32'h5555, 1'b1, slot, 32'h0);
    check("R2", "action pass", out_action, 0);
    check("R2", "fields kept", {out_src, out_value, out_seq}, {32'hC11E_0001, 32'h5555, 16'h9});
    check("R2", "no strobes", {stat_valid, inval_strobe, store_we}, 3'b000);
    probe_read(slot, a);
    check("R2", "slot still served", a, 1);
  endtask

  task automatic t_from_server(input logic [3:0] slot);
    logic [1:0] a;
    send(KVP, 1'b1, 2'd1, 16'hA, 16'h45, 32'h6666, 1'b1, slot, 32'h0);
    check("R9", "action forward", out_action, 2);
    check("R9", "fields kept", {out_dst, out_value}, {32'h5E5E_0002, 32'h6666});
    check("R9", "no strobes", {stat_valid, inval_strobe}, 2'b00);
    probe_read(slot, a);
    check("R9", "slot still served", a, 1);
  endtask

  task automatic t_idle;
    in_valid = 1'b0;
    @(negedge clk);
    check("R10", "quiet when idle", {out_valid, stat_valid, inval_strobe, store_we}, 4'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill(4'd3, 32'h1234_5678);
    t_read_hit();
    t_read_miss();
    t_read_invalid();
    t_passthru(4'd3);
    t_from_server(4'd3);
    t_write_hit(2'd1, 4'd3);
    t_fill(4'd7, 32'h0BAD_CAFE);
    t_write_hit(2'd2, 4'd7);
    t_write_miss();
    t_idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule